// File: doc/BRIEF.md
# Latched Fault Supervisor with Soft-Shutdown

This block is the digital fault manager of a multiphase buck regulator controller. It receives three comparator flags (output overvoltage, output undervoltage below 70% of nominal, over-temperature), a shutdown pin level, a test-mode detect from a high-voltage sense circuit and the power-on reset. It owns the live reference code fed to the DAC, moves it one LSB per clock toward the requested target, and produces per-phase high-side and low-side gate enables, a regulator-OK flag and a sticky fault latch with its first cause.

Two responses exist. An overvoltage crowbars the output at once: every high-side enable drops, every low-side enable rises and the reference goes to zero in the same clock. An undervoltage or over-temperature fault instead ramps the reference down to zero one LSB per clock with switching still enabled, and only then parks the drivers with the low side on. Undervoltage checking and the regulator-OK flag are blanked while the code moves and for a fixed number of clocks after it arrives. All control pins are plain levels; there is no streaming data path and no back-pressure. The shutdown and test-mode inputs are taken as synchronous to the clock.

Top module: `fault_supervisor`

## Requirements
- R1: An overvoltage flag seen in the running state drives, at the same clock edge, every hs_en bit to 0, every ls_en bit to 1 and dac_code to 0, sets fault_latched and records cause 1; if undervoltage or over-temperature arrive in the same cycle, overvoltage wins.
- R2: An undervoltage flag seen while the running state is not blanked sets fault_latched, records cause 2 and starts a soft shutdown: both enables stay on and dac_code steps down by one per clock.
- R3: An over-temperature flag seen in the running state sets fault_latched, records cause 3 and starts the same soft shutdown as R2.
- R4: When the soft-shutdown ramp reaches code 0, hs_en becomes all 0 and ls_en all 1, and this is held while the latch stays set.
- R5: dac_code moves by exactly one LSB per clock toward the target; a new target_code is taken at the next clock edge and stepping starts one clock later.
- R6: While dac_code differs from its target and for BLANK_CYC (default 24) clocks after it reaches the target, undervoltage is ignored and vr_ok is 0; vr_ok is 1 only in the running state outside that window.
- R7: Once set, fault_latched and fault_cause hold; only a rising edge of shdn_n, a power-on reset or test mode (R8) clear them.
- R8: While test_mode is 1, all three fault detections are disabled, and at the next clock edge the latch and cause are cleared and the controller runs.
- R9: After reset, and one clock after shdn_n goes low, both enables are all 0 and dac_code is 0; a latch already set stays set while shdn_n is low.
- R10: fault_cause is 0 while the latch is clear and otherwise keeps the first cause (1 overvoltage, 2 undervoltage, 3 over-temperature) until the latch is cleared.
- R11: An overvoltage flag during a soft shutdown or a parked fault switches to the crowbar outputs of R1 at once, with dac_code 0, keeping the first cause.
- R12: Comparator flags pass a two-flop synchronizer: a flag raised before clock edge 1 acts on the outputs at edge 3 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-on reset, active low |
| shdn_n | input | 1 | Shutdown pin level, low means shut down |
| test_mode | input | 1 | High-voltage test detect; suppresses faults, clears latch |
| ov_raw | input | 1 | Overvoltage comparator flag, asynchronous |
| uv_raw | input | 1 | Undervoltage comparator flag, asynchronous |
| ot_raw | input | 1 | Over-temperature comparator flag, asynchronous |
| target_code | input | CODE_W | Requested reference code |
| hs_en | output | PHASES | High-side gate enable per phase |
| ls_en | output | PHASES | Low-side gate enable per phase |
| dac_code | output | CODE_W | Live reference code to the DAC |
| vr_ok | output | 1 | Regulator-OK flag |
| fault_latched | output | 1 | Sticky fault latch |
| fault_cause | output | 2 | First fault cause: 0 none, 1 OV, 2 UV, 3 OT |

## Verification
On every cycle the checker confirms that the code never jumps except to zero, that parked or crowbarred drivers always coincide with a zero code, that a synchronized overvoltage crowbars at the next edge, that vr_ok implies a still code, that the cause stays frozen while latched, that shutdown forces everything off and that test mode empties the latch. Only the scenarios show the exact blanking length after a code change, the synchronizer delay, the soft-ramp slope and its hand-over to parking, the priority of simultaneous causes, and that a shutdown toggle rather than removal of the fault releases the latch.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_RUN     = 3'd1,
    ST_SOFT    = 3'd2,
    ST_PARK    = 3'd3,
    ST_CROWBAR = 3'd4
  } fs_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_OV   = 2'd1,
    CAUSE_UV   = 2'd2,
    CAUSE_OT   = 2'd3
  } fs_cause_e;
endpackage

// File: rtl/fs_sync.sv
module fs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/fs_slew.sv
module fs_slew #(
  parameter int CODE_W    = 5,
  parameter int BLANK_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] tgt_in,
  input  logic              force_zero,
  output logic [CODE_W-1:0] code,
  output logic              blanked
);
  localparam int CNT_W = $clog2(BLANK_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BLANK_CYC);

  logic [CODE_W-1:0] tgt_q, code_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      code_q <= '0;
      cnt_q  <= CNT_LOAD;
    end else begin
      tgt_q <= tgt_in;
      if (force_zero)          code_q <= '0;
      else if (code_q < tgt_q) code_q <= code_q + CODE_W'(1);
      else if (code_q > tgt_q) code_q <= code_q - CODE_W'(1);
      if (code_q != tgt_q)     cnt_q <= CNT_LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign code    = code_q;
  assign blanked = (code_q != tgt_q) || (cnt_q != '0);
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import fs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      shdn_n,
  input  logic      test_mode,
  input  logic      ov_s,
  input  logic      uv_s,
  input  logic      ot_s,
  input  logic      blanked,
  input  logic      code_zero,
  output fs_state_e state_q,
  output fs_state_e state_d,
  output logic      latched,
  output fs_cause_e cause
);
  logic      shdn_q;
  logic      ov_det, uv_det, ot_det, set_fault, clear_fault;
  fs_cause_e new_cause;

  always_comb begin
    ov_det = ov_s && !test_mode;
    uv_det = uv_s && !blanked && !test_mode;
    ot_det = ot_s && !test_mode;
    state_d = state_q;
    if (!shdn_n)        state_d = ST_OFF;
    else if (test_mode) state_d = ST_RUN;
    else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_RUN;
        ST_RUN: begin
          if (ov_det)                state_d = ST_CROWBAR;
          else if (ot_det || uv_det) state_d = ST_SOFT;
        end
        ST_SOFT: begin
          if (ov_det)         state_d = ST_CROWBAR;
          else if (code_zero) state_d = ST_PARK;
        end
        ST_PARK: if (ov_det) state_d = ST_CROWBAR;
        default: state_d = state_q;
      endcase
    end
    set_fault   = shdn_n && (state_q == ST_RUN) && (ov_det || ot_det || uv_det);
    clear_fault = test_mode || (shdn_n && !shdn_q);
    if (ov_det)      new_cause = CAUSE_OV;
    else if (ot_det) new_cause = CAUSE_OT;
    else             new_cause = CAUSE_UV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      shdn_q  <= 1'b1;
      latched <= 1'b0;
      cause   <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      shdn_q  <= shdn_n;
      if (clear_fault) begin
        latched <= 1'b0;
        cause   <= CAUSE_NONE;
      end else if (set_fault) begin
        latched <= 1'b1;
        if (!latched) cause <= new_cause;
      end
    end
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fs_pkg::*;
#(
  parameter int PHASES      = 2,
  parameter int CODE_W      = 5,
  parameter int BLANK_CYC   = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n,
  input  logic              test_mode,
  input  logic              ov_raw,
  input  logic              uv_raw,
  input  logic              ot_raw,
  input  logic [CODE_W-1:0] target_code,
  output logic [PHASES-1:0] hs_en,
  output logic [PHASES-1:0] ls_en,
  output logic [CODE_W-1:0] dac_code,
  output logic              vr_ok,
  output logic              fault_latched,
  output logic [1:0]        fault_cause
);
  localparam int NFLAG = 3;

  logic [NFLAG-1:0]  flags_s;
  logic              ov_s, uv_s, ot_s, blanked;
  logic [CODE_W-1:0] tgt_eff;
  logic              force_zero;
  fs_state_e         state_q, state_d;
  fs_cause_e         cause;

  fs_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ot_raw, uv_raw, ov_raw}),
    .dout (flags_s)
  );
  assign ov_s = flags_s[0];
  assign uv_s = flags_s[1];
  assign ot_s = flags_s[2];

  fs_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .shdn_n   (shdn_n),
    .test_mode(test_mode),
    .ov_s     (ov_s),
    .uv_s     (uv_s),
    .ot_s     (ot_s),
    .blanked  (blanked),
    .code_zero(dac_code == '0),
    .state_q  (state_q),
    .state_d  (state_d),
    .latched  (fault_latched),
    .cause    (cause)
  );

  assign tgt_eff    = (state_d == ST_RUN) ? target_code : '0;
  assign force_zero = (state_d == ST_OFF) || (state_d == ST_CROWBAR);

  fs_slew #(.CODE_W(CODE_W), .BLANK_CYC(BLANK_CYC)) u_slew (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_in    (tgt_eff),
    .force_zero(force_zero),
    .code      (dac_code),
    .blanked   (blanked)
  );

  always_comb begin
    hs_en = '0;
    ls_en = '0;
    unique case (state_q)
      ST_RUN, ST_SOFT:     begin hs_en = '1; ls_en = '1; end
      ST_PARK, ST_CROWBAR: begin hs_en = '0; ls_en = '1; end
      default:             begin hs_en = '0; ls_en = '0; end
    endcase
  end

  assign vr_ok       = (state_q == ST_RUN) && !blanked;
  assign fault_cause = cause;
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int PHASES = 2,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shdn_n,
  input logic              test_mode,
  input logic              ov_s,
  input logic [PHASES-1:0] hs_en,
  input logic [PHASES-1:0] ls_en,
  input logic [CODE_W-1:0] dac_code,
  input logic              vr_ok,
  input logic              fault_latched,
  input logic [1:0]        fault_cause
);
  AST_SLEW_ONE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> (dac_code == $past(dac_code) + CODE_W'(1)) ||
    (dac_code == $past(dac_code) - CODE_W'(1)) || (dac_code == '0)); // R5
  AST_PARK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en == '0 && ls_en == '1) |-> (dac_code == '0)); // R4
  AST_OV_CROWBAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_s && shdn_n && !test_mode && hs_en != '0) |=>
    (hs_en == '0 && ls_en == '1 && dac_code == '0)); // R11
  AST_OK_CODE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    vr_ok |-> (dac_code == $past(dac_code))); // R6
  AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && $past(fault_latched)) |-> (fault_cause == $past(fault_cause))); // R10
  AST_CAUSE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_latched |-> (fault_cause == 2'd0)); // R10
  AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (hs_en == '0 && ls_en == '0 && dac_code == '0)); // R9
  AST_TEST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && shdn_n) |=> !fault_latched); // R8
endmodule

bind fault_supervisor fs_checker #(.PHASES(PHASES), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/sim_fault_supervisor.sv
`timescale 1ns/1ps
module sim_fault_supervisor;
  localparam int PH = 2;
  localparam int CW = 5;

  typedef struct {
    string          req;
    logic [PH-1:0]  hs, ls;
    logic [CW-1:0]  code;
    logic           ok, lat;
    logic [1:0]     cause;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, shdn_n = 1'b0, test_mode = 1'b0;
  logic ov_raw = 1'b0, uv_raw = 1'b0, ot_raw = 1'b0;
  logic [CW-1:0] target_code = 5'd10;
  logic [PH-1:0] hs_en, ls_en;
  logic [CW-1:0] dac_code;
  logic vr_ok, fault_latched;
  logic [1:0] fault_cause;

  int n_checks = 0, n_errors = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  fault_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .test_mode(test_mode),
    .ov_raw(ov_raw), .uv_raw(uv_raw), .ot_raw(ot_raw), .target_code(target_code),
    .hs_en(hs_en), .ls_en(ls_en), .dac_code(dac_code), .vr_ok(vr_ok),
    .fault_latched(fault_latched), .fault_cause(fault_cause)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic hs, input logic ls,
                            input int code, input logic ok, input logic lat, input int cause);
    exp_t e;
    e.req = req; e.hs = {PH{hs}}; e.ls = {PH{ls}}; e.code = CW'(code);
    e.ok = ok; e.lat = lat; e.cause = 2'(cause);
    sb.push_back(e);
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if ({hs_en, ls_en, dac_code, vr_ok, fault_latched, fault_cause} !==
            {e.hs, e.ls, e.code, e.ok, e.lat, e.cause}) begin
          n_errors++;
          $display("FAIL %s actual hs=%b ls=%b code=%0d ok=%b lat=%b cause=%0d expected hs=%b ls=%b code=%0d ok=%b lat=%b cause=%0d",
                   e.req, hs_en, ls_en, dac_code, vr_ok, fault_latched, fault_cause,
                   e.hs, e.ls, e.code, e.ok, e.lat, e.cause);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    step(5);
    expect_out("R9 reset state", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1; step(3);
    expect_out("R9 held in shutdown", 0, 0, 0, 0, 0, 0);
    shdn_n = 1'b1; step(1);
    expect_out("R5 start running", 1, 1, 0, 0, 0, 0);
    step(3);
    expect_out("R5 one LSB per clock", 1, 1, 3, 0, 0, 0);
    step(7);
    expect_out("R6 arrival blanked", 1, 1, 10, 0, 0, 0);
    step(23);
    expect_out("R6 last blanked cycle", 1, 1, 10, 0, 0, 0);
    step(1);
    expect_out("R6 blanking over", 1, 1, 10, 1, 0, 0);
    target_code = 5'd20; uv_raw = 1'b1; step(15);
    expect_out("R6 uv ignored while blanked", 1, 1, 20, 0, 0, 0);
    uv_raw = 1'b0; step(20);
    expect_out("R6 ok after new target", 1, 1, 20, 1, 0, 0);
    uv_raw = 1'b1; step(3);
    expect_out("R2 uv latches soft shutdown", 1, 1, 20, 0, 1, 2);
    step(3);
    expect_out("R2 ramp down", 1, 1, 17, 0, 1, 2);
    step(20);
    expect_out("R4 parked at zero", 0, 1, 0, 0, 1, 2);
    uv_raw = 1'b0; ot_raw = 1'b1; step(6);
    expect_out("R10 later cause ignored", 0, 1, 0, 0, 1, 2);
    ot_raw = 1'b0; shdn_n = 1'b0; step(1);
    expect_out("R9 shutdown keeps latch", 0, 0, 0, 0, 1, 2);
    step(3); shdn_n = 1'b1; step(1);
    expect_out("R7 toggle clears latch", 1, 1, 0, 0, 0, 0);
    step(49);
    expect_out("R5 settled at target", 1, 1, 20, 1, 0, 0);
    ov_raw = 1'b1; step(2);
    expect_out("R12 sync delay", 1, 1, 20, 1, 0, 0);
    step(1);
    expect_out("R1 crowbar", 0, 1, 0, 0, 1, 1);
    ov_raw = 1'b0; step(10);
    expect_out("R7 latch holds", 0, 1, 0, 0, 1, 1);
    test_mode = 1'b1; step(1);
    expect_out("R8 test clears latch", 1, 1, 0, 0, 0, 0);
    ov_raw = 1'b1; uv_raw = 1'b1; ot_raw = 1'b1; step(10);
    expect_out("R8 faults disabled", 1, 1, 10, 0, 0, 0);
    ov_raw = 1'b0; uv_raw = 1'b0; ot_raw = 1'b0; step(3);
    test_mode = 1'b0; step(50);
    expect_out("R8 normal after test", 1, 1, 20, 1, 0, 0);
    ot_raw = 1'b1; step(3);
    expect_out("R3 thermal soft shutdown", 1, 1, 20, 0, 1, 3);
    ov_raw = 1'b1; step(3);
    expect_out("R11 ov overrides ramp", 0, 1, 0, 0, 1, 3);
    ov_raw = 1'b0; ot_raw = 1'b0; shdn_n = 1'b0; step(2);
    shdn_n = 1'b1; step(50);
    expect_out("R7 rerun after toggle", 1, 1, 20, 1, 0, 0);
    ov_raw = 1'b1; ot_raw = 1'b1; step(3);
    expect_out("R1 ov priority over thermal", 0, 1, 0, 0, 1, 1);
    step(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule